// File: doc/BRIEF.md
# TDM Audio Serial Transmit Port

This block turns a stream of audio samples into a time-division-multiplexed serial bit stream. Samples arrive on a valid/ready input and wait in a small internal FIFO. A sample is accepted on every system-clock cycle where `s_valid` and `s_ready` are both high. `s_ready` drops when the FIFO is full or is being flushed. While it is low, the source must hold its sample and keep `s_valid` asserted. The port is always a slave. It takes the bit clock and the frame sync from the companion receive port. Both are sampled in the system clock domain, and the port acts on their edges.

Each frame begins at a sync edge. After a programmable delay, the port sends a programmable number of slots. Each slot has an encoded word length and carries one FIFO sample of an encoded sample size. The sample is placed at the start or the end of the slot, and the rest of the slot is filled with zeros. If the FIFO is empty when a slot begins, the port repeats the previous sample or sends zeros. Two plain configuration inputs load a control word and a serial-port word. The data-request output tells a feeder when the FIFO level has fallen to a programmed threshold.

Top module: `tdm_tx_port`

## Requirements
- R1: After reset, `sdata` is 0, `fifo_level` is 0, `s_ready` is 1, and the port is disabled.
- R2: The FIFO holds DEPTH (16) samples. `s_ready` is 1 exactly when the FIFO is not full and no flush is active. A sample is stored when `s_valid` and `s_ready` are both high. `fifo_level` shows the number of stored samples.
- R3: `dreq` is 1 exactly when `fifo_level` is less than or equal to `dreq_level`.
- R4: The frame sync is sampled on the rising bit-clock edges. It is active-high when serial-port bit 16 is 1 and active-low when that bit is 0. A frame starts at the first rising edge where the sync is active after being inactive. Let D be the value of control bits [20:19]. On the first D falling edges after the start, `sdata` is 0. The first data bit is driven on falling edge D+1.
- R5: Data changes on falling bit-clock edges and is sent MSB first. A frame has (control bits [10:8]) + 1 slots of W bits each. One FIFO sample is popped at the first bit of each slot.
- R6: Two fields use the same size code: the slot word length W in control bits [7:5] and the sample size S in control bits [2:0]. The codes are 0=8, 1=12, 2=16, 3=20 and 4=24 bits. Codes 5, 6 and 7 mean 32 bits. When S is larger than W, S is taken as W.
- R7: The sample is the low S bits of a FIFO entry. If control bit 3 is 1, the sample fills the first S bits of the slot. If bit 3 is 0, it fills the last S bits. All other slot bits are 0.
- R8: Suppose the FIFO is empty at the first bit of a slot. If control bit 15 is 1, the slot carries zeros. If bit 15 is 0, the slot repeats the most recently popped sample. This value is zero after the port has been stopped.
- R9: After the last slot of a frame, `sdata` stays 0 until the next frame starts.
- R10: A serial-port write takes effect only when bit 31 of the written word is 1. Bit 0 enables the port and bit 1 holds the port in reset. While the port is not enabled, or is held in reset, `sdata` is 0 and no samples are popped. Bit 2 empties the FIFO and blocks input while it is set. Bit 18 has no effect.
- R11: `sdata` changes only at a falling bit-clock edge, or when the port stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Load the control word |
| ctl_wdata | input | 32 | Control word value |
| sp_wr | input | 1 | Write the serial-port word |
| sp_wdata | input | 32 | Serial-port word value (bit 31 gates the write) |
| dreq_level | input | LW (5) | Data-request threshold |
| s_valid | input | 1 | Sample stream valid |
| s_data | input | 32 | Sample stream data |
| s_ready | output | 1 | Sample stream ready |
| bclk | input | 1 | Bit clock from the receive port |
| fsync | input | 1 | Frame sync from the receive port |
| sdata | output | 1 | Serial data out |
| dreq | output | 1 | Data request |
| fifo_level | output | LW (5) | Current FIFO occupancy |

## Verification
The assertions assume that each `bclk` level lasts at least one system clock, so a rising edge and a falling edge never fall in the same cycle. They also assume the control word is not rewritten while a frame is being sent. The bench drives the bit clock at four system clocks per period and changes the sync only while `bclk` is low. It changes configuration only while the port is disabled, except for the flush, reset and threshold tests. The stream source holds `s_data` stable until the sample is accepted.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int SAMPLE_W = 32;

  typedef struct packed {
    logic       fill_zero;
    logic [1:0] dly;
    logic [2:0] frlen;
    logic [2:0] wlen;
    logic       left;
    logic [2:0] ssz;
  } ctl_t;

  function automatic logic [5:0] code_bits(input logic [2:0] code);
    case (code)
      3'd0:    code_bits = 6'd8;
      3'd1:    code_bits = 6'd12;
      3'd2:    code_bits = 6'd16;
      3'd3:    code_bits = 6'd20;
      3'd4:    code_bits = 6'd24;
      default: code_bits = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/tdm_tx_fifo.sv
module tdm_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0));
endmodule

// File: rtl/tdm_tx_serial.sv
module tdm_tx_serial import tdm_tx_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  ctl_t                ctl,
  input  logic                fs_high,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                fifo_empty,
  input  logic [SAMPLE_W-1:0] fifo_dout,
  output logic                pop,
  output logic                sdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_DLY, ST_DATA, ST_TAIL} st_t;

  st_t                 st;
  logic                bclk_q, fs_prev;
  logic [1:0]          dly_cnt;
  logic [5:0]          bit_cnt;
  logic [2:0]          slot_cnt;
  logic [SAMPLE_W-1:0] sh, last, pick, mask, shaped;
  logic [5:0]          wbits, sbits, seff;
  logic                rise, fall, fs_act, slot_first;

  assign rise   = bclk & ~bclk_q;
  assign fall   = ~bclk & bclk_q;
  assign fs_act = (fsync == fs_high);
  assign wbits  = code_bits(ctl.wlen);
  assign sbits  = code_bits(ctl.ssz);
  assign seff   = (sbits > wbits) ? wbits : sbits;
  assign slot_first = (st == ST_DATA) && (bit_cnt == '0);
  assign pop    = run && fall && slot_first && !fifo_empty;

  always_comb begin
    pick = !fifo_empty ? fifo_dout : (ctl.fill_zero ? '0 : last);
    mask = (seff == 6'd32) ? '1 : ((32'd1 << seff) - 32'd1);
    shaped = ctl.left ? ((pick & mask) << (6'd32 - seff))
                      : ((pick & mask) << (6'd32 - wbits));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      fs_prev <= 1'b1;
      st <= ST_IDLE;
      dly_cnt <= '0;
      bit_cnt <= '0;
      slot_cnt <= '0;
      sh <= '0;
      last <= '0;
      sdata <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (!run) begin
        st <= ST_IDLE;
        fs_prev <= 1'b1;
        last <= '0;
        sdata <= 1'b0;
      end else if (rise) begin
        fs_prev <= fs_act;
        if (fs_act && !fs_prev) begin
          st <= (ctl.dly == '0) ? ST_DATA : ST_DLY;
          dly_cnt <= ctl.dly;
          bit_cnt <= '0;
          slot_cnt <= '0;
        end
      end else if (fall) begin
        case (st)
          ST_DLY: begin
            sdata <= 1'b0;
            dly_cnt <= dly_cnt - 2'd1;
            if (dly_cnt == 2'd1) st <= ST_DATA;
          end
          ST_DATA: begin
            if (slot_first) begin
              sdata <= shaped[SAMPLE_W-1];
              sh <= shaped << 1;
              if (!fifo_empty) last <= fifo_dout;
            end else begin
              sdata <= sh[SAMPLE_W-1];
              sh <= sh << 1;
            end
            if (bit_cnt == wbits - 6'd1) begin
              bit_cnt <= '0;
              if (slot_cnt == ctl.frlen) st <= ST_TAIL;
              else slot_cnt <= slot_cnt + 3'd1;
            end else begin
              bit_cnt <= bit_cnt + 6'd1;
            end
          end
          ST_TAIL: sdata <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  a_r11_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata != $past(sdata)) |-> ($past(fall) || !$past(run)));
  a_r9_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fall && st == ST_TAIL) |=> !sdata);
  a_r4_delay_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fall && st == ST_DLY) |=> !sdata);
endmodule

// File: rtl/tdm_tx_port.sv
module tdm_tx_port import tdm_tx_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [31:0]         ctl_wdata,
  input  logic                sp_wr,
  input  logic [31:0]         sp_wdata,
  input  logic [LW-1:0]       dreq_level,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  input  logic                bclk,
  input  logic                fsync,
  output logic                sdata,
  output logic                dreq,
  output logic [LW-1:0]       fifo_level
);
  ctl_t                ctl;
  logic                en, srst, flush, fs_high;
  logic                run, push, pop, full, empty;
  logic [SAMPLE_W-1:0] fifo_dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      en <= 1'b0;
      srst <= 1'b0;
      flush <= 1'b0;
      fs_high <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl.ssz       <= ctl_wdata[2:0];
        ctl.left      <= ctl_wdata[3];
        ctl.wlen      <= ctl_wdata[7:5];
        ctl.frlen     <= ctl_wdata[10:8];
        ctl.fill_zero <= ctl_wdata[15];
        ctl.dly       <= ctl_wdata[20:19];
      end
      if (sp_wr && sp_wdata[31]) begin
        en      <= sp_wdata[0];
        srst    <= sp_wdata[1];
        flush   <= sp_wdata[2];
        fs_high <= sp_wdata[16];
      end
    end
  end

  assign run     = en & ~srst;
  assign s_ready = ~full & ~flush;
  assign push    = s_valid & s_ready;
  assign dreq    = (fifo_level <= dreq_level);

  tdm_tx_fifo #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .din(s_data),
    .pop(pop), .dout(fifo_dout), .level(fifo_level), .full(full), .empty(empty)
  );

  tdm_tx_serial u_ser (
    .clk(clk), .rst_n(rst_n), .run(run), .ctl(ctl), .fs_high(fs_high),
    .bclk(bclk), .fsync(fsync), .fifo_empty(empty), .fifo_dout(fifo_dout),
    .pop(pop), .sdata(sdata)
  );

  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sdata);
endmodule

// File: tb/sim_tdm_tx_port.sv
module sim_tdm_tx_port;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, sp_wr = 0;
  logic [31:0] ctl_wdata = 0, sp_wdata = 0;
  logic [LW-1:0] dreq_level = 1;
  logic s_valid = 0, s_ready;
  logic [31:0] s_data = 0;
  logic bclk = 0, fsync = 0;
  logic sdata, dreq;
  logic [LW-1:0] fifo_level;

  int errors = 0, checks = 0;
  string cur_tag = "R1";
  bit bclk_on = 0, push_on = 0, fs_high_drv = 0;
  int ph = 0, bidx = 0;
  localparam int FR_BITS = 80;

  always #2.5 clk = ~clk;

  tdm_tx_port #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sp_wr(sp_wr), .sp_wdata(sp_wdata), .dreq_level(dreq_level),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .bclk(bclk), .fsync(fsync), .sdata(sdata), .dreq(dreq), .fifo_level(fifo_level)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mq[$];
  int m_ssz, m_wlen, m_frlen, m_dly;
  bit m_left, m_fill, m_en, m_srst, m_flush, m_fsh;
  bit m_bprev, m_fsprev, m_started, m_sd, m_evt;
  int m_p;
  logic [31:0] m_last, m_cur;

  function automatic int bits_of(input int code);
    case (code)
      0: return 8; 1: return 12; 2: return 16; 3: return 20; 4: return 24;
      default: return 32;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_ssz = 0; m_wlen = 0; m_frlen = 0; m_dly = 0;
      m_left = 0; m_fill = 0; m_en = 0; m_srst = 0; m_flush = 0; m_fsh = 0;
      m_bprev = 0; m_fsprev = 1; m_started = 0; m_sd = 0; m_p = 0;
      m_last = 0; m_cur = 0; m_evt = 0;
    end else begin
      bit rise, fall, run, can_push;
      rise = bclk && !m_bprev;
      fall = !bclk && m_bprev;
      run = m_en && !m_srst;
      can_push = s_valid && !m_flush && (mq.size() < DEPTH);
      m_evt = fall || !run;
      if (!run) begin
        m_sd = 0; m_started = 0; m_last = 0; m_fsprev = 1;
      end else if (rise) begin
        bit act;
        act = (fsync == m_fsh);
        if (act && !m_fsprev) begin m_started = 1; m_p = 0; end
        m_fsprev = act;
      end else if (fall && m_started) begin
        if (m_p < m_dly) m_sd = 0;
        else begin
          int w, s, k, slot, b, j;
          w = bits_of(m_wlen);
          s = bits_of(m_ssz);
          if (s > w) s = w;
          k = m_p - m_dly;
          slot = k / w;
          b = k % w;
          if (slot > m_frlen) m_sd = 0;
          else begin
            if (b == 0) begin
              if (mq.size() > 0) begin m_cur = mq.pop_front(); m_last = m_cur; end
              else m_cur = m_fill ? 32'd0 : m_last;
            end
            j = w - 1 - b;
            if (m_left) m_sd = (j >= w - s) ? m_cur[j - (w - s)] : 1'b0;
            else        m_sd = (j < s) ? m_cur[j] : 1'b0;
          end
        end
        m_p++;
      end
      if (m_flush) mq.delete();
      else if (can_push) mq.push_back(s_data);
      if (ctl_wr) begin
        m_ssz = int'(ctl_wdata[2:0]); m_left = ctl_wdata[3];
        m_wlen = int'(ctl_wdata[7:5]); m_frlen = int'(ctl_wdata[10:8]);
        m_fill = ctl_wdata[15]; m_dly = int'(ctl_wdata[20:19]);
      end
      if (sp_wr && sp_wdata[31]) begin
        m_en = sp_wdata[0]; m_srst = sp_wdata[1];
        m_flush = sp_wdata[2]; m_fsh = sp_wdata[16];
      end
      m_bprev = bclk;
    end
  end

  logic prev_sd = 0;
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(sdata === m_sd, {"R5/", cur_tag}, "sdata", {31'd0, sdata}, {31'd0, m_sd});
      chk(s_ready === (!m_flush && mq.size() < DEPTH), "R2", "s_ready",
          {31'd0, s_ready}, {31'd0, (!m_flush && mq.size() < DEPTH)});
      chk(fifo_level === LW'(mq.size()), "R2", "fifo_level", 32'(fifo_level), 32'(mq.size()));
      chk(dreq === (mq.size() <= int'(dreq_level)), "R3", "dreq",
          {31'd0, dreq}, {31'd0, (mq.size() <= int'(dreq_level))});
      chk(sdata === prev_sd || m_evt, "R11", "sdata change off edge",
          {31'd0, sdata}, {31'd0, prev_sd});
      prev_sd = sdata;
    end
  end

  // ---------------- stimulus ----------------
  always @(negedge clk) begin
    if (bclk_on) begin
      ph = ph + 1;
      if (ph == 4) begin ph = 0; bidx = (bidx + 1) % FR_BITS; end
      bclk = (ph >= 2);
      fsync = fs_high_drv ? (bidx == 0) : (bidx != 0);
    end
    if (!s_valid || s_ready) begin
      s_valid = push_on && ($urandom % 4 != 0);
      s_data = $urandom;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wr_sp(input logic [31:0] v);
    @(negedge clk); sp_wr = 1; sp_wdata = v;
    @(negedge clk); sp_wr = 0;
  endtask

  function automatic logic [31:0] ctlw(input int ssz, input bit left, input int wlen,
                                       input int frlen, input bit fill, input int dly);
    return 32'(ssz) | (32'(left) << 3) | (32'(wlen) << 5) | (32'(frlen) << 8)
         | (32'(fill) << 15) | (32'(dly) << 19);
  endfunction

  localparam logic [31:0] WE = 32'h8000_0000;
  localparam logic [31:0] EN = 32'h1;
  localparam logic [31:0] HI = 32'h1_0000;

  task automatic frames(input int n);
    wait_clk(n * FR_BITS * 4);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    cur_tag = "R1";
    chk(sdata === 1'b0, "R1", "reset sdata", {31'd0, sdata}, 0);
    chk(s_ready === 1'b1, "R1", "reset s_ready", {31'd0, s_ready}, 1);
    chk(fifo_level === '0, "R1", "reset level", 32'(fifo_level), 0);

    bclk_on = 1; fs_high_drv = 1;
    // write without write-enable bit: port stays disabled
    cur_tag = "R10";
    wr_ctl(ctlw(2, 1, 5, 1, 0, 1));
    wr_sp(EN | HI);
    push_on = 1;
    frames(1);
    chk(sdata === 1'b0, "R10", "sdata with ungated write", {31'd0, sdata}, 0);
    cur_tag = "R2";
    chk(fifo_level === LW'(DEPTH), "R2", "level at full", 32'(fifo_level), DEPTH);
    chk(s_ready === 1'b0, "R2", "back-pressure", {31'd0, s_ready}, 0);

    cur_tag = "R5";
    wr_sp(WE | EN | HI);
    frames(3);

    cur_tag = "R7";
    wr_sp(WE | HI);
    wr_ctl(ctlw(4, 0, 5, 1, 0, 1));
    wr_sp(WE | EN | HI);
    frames(3);

    cur_tag = "R6";
    wr_sp(WE | HI);
    wr_ctl(ctlw(1, 1, 2, 3, 0, 0));
    wr_sp(WE | EN | HI);
    frames(3);
    wr_sp(WE | HI);
    wr_ctl(ctlw(0, 0, 7, 0, 0, 2));
    wr_sp(WE | EN | HI);
    frames(2);
    wr_sp(WE | HI);
    wr_ctl(ctlw(5, 0, 1, 1, 0, 1));
    wr_sp(WE | EN | HI);
    frames(2);

    cur_tag = "R4";
    wr_sp(WE | HI);
    wr_ctl(ctlw(3, 1, 5, 1, 0, 3));
    fs_high_drv = 0;
    wr_sp(WE | EN | 32'h4_0000);
    frames(3);

    cur_tag = "R8";
    push_on = 0;
    frames(10);
    chk(fifo_level === '0, "R8", "drained", 32'(fifo_level), 0);
    wr_sp(WE);
    wr_ctl(ctlw(3, 1, 5, 1, 1, 3));
    wr_sp(WE | EN);
    frames(2);

    cur_tag = "R9";
    wr_sp(WE);
    wr_ctl(ctlw(2, 0, 2, 0, 0, 1));
    push_on = 1;
    wr_sp(WE | EN);
    frames(3);

    cur_tag = "R3";
    dreq_level = 8; frames(1);
    dreq_level = 0; frames(1);
    dreq_level = 16; frames(1);
    dreq_level = 1;

    cur_tag = "R10";
    wr_sp(WE | EN | 32'h4);
    wait_clk(3);
    chk(fifo_level === '0, "R10", "flush level", 32'(fifo_level), 0);
    chk(s_ready === 1'b0, "R10", "flush blocks input", {31'd0, s_ready}, 0);
    wr_sp(WE | EN);
    frames(1);
    wr_sp(WE | EN | 32'h2);
    frames(1);
    chk(sdata === 1'b0, "R10", "port reset quiet", {31'd0, sdata}, 0);
    wr_sp(WE | EN);
    frames(2);

    push_on = 0;
    wait_clk(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule